// File: doc/BRIEF.md
# Programmable Clock Output Divider Channel

This block is one output lane of a multi-output clock generator. It chooses either a fast synthesised clock or the reference clock as its working clock. It divides that clock by a programmable ratio and drives the lane's output. The ratio is a 5-bit value of either parity multiplied by a power of two from 1 to 8. The waveform keeps an exact half-period high time for every ratio, odd ratios included.

The output is modelled as a data bit plus a drive-enable bit. A master enable and an active-low power-down both gate it. A configuration bit selects what a gated lane does: release the pin (high impedance) or drive it low. New ratio settings are held off until the current output period completes, so a reconfiguration never produces a short pulse. Power-down parks the counter at a known phase. When power-down is released, the next rising edge of the working clock starts a full high phase.

Top module: `clkdiv_channel`

## Requirements
- R1: The output period is N working-clock cycles, where N = Peff × 2^cfg_post, Peff is cfg_p (treated as 1 when cfg_p is 0 or 1), and cfg_post codes 0,1,2,3 select ×1, ×2, ×4, ×8.
- R2: For even N the output is high for exactly N/2 working-clock cycles, starting at a rising edge of the working clock.
- R3: For odd N greater than 1 the output is high for exactly N/2 working-clock cycles (a whole number of cycles plus one half), using a falling-edge stage.
- R4: When N is 1 the working clock is passed to out_dat unchanged.
- R5: cfg_src = 0 selects the fast clock (vco_clk) and cfg_src = 1 selects ref_clk. It is changed only while pdb_n is low.
- R6: A change to cfg_p or cfg_post takes effect at the end of the output period in progress. The pulse in progress completes with its old width.
- R7: With oem = 1 and pdb_n = 1 the output is driven (out_oe = 1). With oem = 0, out_dat is 0.
- R8: While the lane is gated, cfg_drive_low = 0 gives out_oe = 0 (high impedance) and cfg_drive_low = 1 gives out_oe = 1 with out_dat = 0.
- R9: pdb_n = 0 gates the output as in R8 and holds the counter at its park state. When pdb_n rises, out_dat rises at the first working-clock rising edge and a full period follows.
- R10: While rst_n is low with N > 1, oem = 1 and pdb_n = 1, out_dat is 0 and out_oe is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Fast synthesised source clock |
| ref_clk | input | 1 | Reference source clock |
| rst_n | input | 1 | Active-low reset, synchronous to the working clock |
| cfg_src | input | 1 | Source select: 0 fast clock, 1 reference |
| cfg_p | input | 5 | Primary divide value, odd or even |
| cfg_post | input | 2 | Post-divide code: 2^code |
| cfg_drive_low | input | 1 | Gated state: 0 high impedance, 1 driven low |
| oem | input | 1 | Master output enable, active high |
| pdb_n | input | 1 | Power-down, active low |
| out_dat | output | 1 | Output data value |
| out_oe | output | 1 | Output drive enable |

## Verification
The properties assume that cfg_src moves only while pdb_n is low. They also assume that rst_n and pdb_n are sampled cleanly on the working clock. The stimulus therefore wraps every source change in a power-down window. It releases reset and power-down on a falling edge of the working clock. The properties also assume that cfg_p and cfg_post may change at any time. The bench does this on purpose, including in the middle of a high phase, so that the terminal-count loading is exercised.

// File: rtl/clkdiv_pkg.sv
// Package: shared widths and the ratio computation for the divider channel.
// Assumes the ratio never exceeds the counter range given by CNT_W.
package clkdiv_pkg;
    localparam int P_W    = 5;
    localparam int POST_W = 2;
    localparam int CNT_W  = P_W + (2 ** POST_W) - 1;

    // Effective total ratio: primary value (0/1 mean 1) shifted by the post code.
    function automatic logic [CNT_W-1:0] total_ratio(input logic [P_W-1:0] p,
                                                     input logic [POST_W-1:0] post);
        logic [CNT_W-1:0] base;
        base = (p <= P_W'(1)) ? CNT_W'(1) : CNT_W'(p);
        return base << post;
    endfunction
endpackage

// File: rtl/clkdiv_src_mux.sv
// Source selector: steers one of two clocks to the divider.
// Assumes sel changes only while the divider is held in power-down,
// so a short pulse produced by the switch is never counted.
module clkdiv_src_mux (
    input  logic clk_a,
    input  logic clk_b,
    input  logic sel,
    output logic clk_o
);
    // Pick the working clock.
    always_comb clk_o = sel ? clk_b : clk_a;
endmodule

// File: rtl/clkdiv_core.sv
// Divider core: a rising-edge counter plus a falling-edge stretch stage.
// Settings are captured only at terminal count or while held.
// Assumes rst_n and hold_n are synchronous to div_clk.
module clkdiv_core #(
    parameter int PW = clkdiv_pkg::P_W,
    parameter int QW = clkdiv_pkg::POST_W,
    parameter int CW = clkdiv_pkg::CNT_W
) (
    input  logic          div_clk,
    input  logic          rst_n,
    input  logic          hold_n,
    input  logic [PW-1:0] p_val,
    input  logic [QW-1:0] post_code,
    output logic          clk_raw,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] ratio_o,
    output logic          odd_o,
    output logic          pos_o,
    output logic          neg_o
);
    logic [CW-1:0] cfg_ratio, cfg_half;
    logic          cfg_odd, cfg_byp;
    logic [CW-1:0] act_ratio, act_half, cnt_q, cnt_nxt;
    logic          act_odd, act_byp, pos_q, neg_q, tc;

    // Decode the requested ratio into half length and variant flags.
    always_comb begin
        cfg_ratio = clkdiv_pkg::total_ratio(p_val, post_code);
        cfg_half  = cfg_ratio >> 1;
        cfg_byp   = (cfg_ratio == CW'(1));
        cfg_odd   = cfg_ratio[0] && !cfg_byp;
        cnt_nxt   = cnt_q + CW'(1);
        tc        = (cnt_q >= act_ratio - CW'(1));
    end

    // Rising-edge counter, high-phase flag and terminal-count settings capture.
    always_ff @(posedge div_clk) begin
        if (!rst_n || !hold_n) begin
            cnt_q     <= '1;
            pos_q     <= 1'b0;
            act_ratio <= cfg_ratio;
            act_half  <= cfg_half;
            act_odd   <= cfg_odd;
            act_byp   <= cfg_byp;
        end else if (tc) begin
            cnt_q     <= '0;
            pos_q     <= !cfg_byp;
            act_ratio <= cfg_ratio;
            act_half  <= cfg_half;
            act_odd   <= cfg_odd;
            act_byp   <= cfg_byp;
        end else begin
            cnt_q <= cnt_nxt;
            pos_q <= (cnt_nxt < act_half);
        end
    end

    // Falling-edge copy that stretches odd-ratio high phases by half a cycle.
    always_ff @(negedge div_clk) begin
        if (!rst_n || !hold_n) neg_q <= 1'b0;
        else                   neg_q <= pos_q && act_odd;
    end

    // Form the divided waveform, or pass the clock through for ratio one.
    always_comb begin
        clk_raw = act_byp ? div_clk : (pos_q | neg_q);
        cnt_o   = cnt_q;
        ratio_o = act_ratio;
        odd_o   = act_odd;
        pos_o   = pos_q;
        neg_o   = neg_q;
    end
endmodule

// File: rtl/clkdiv_out_gate.sv
// Output gate: combines master enable and power-down into data and drive-enable.
// Assumes the gated state choice may change at any time and applies at once.
module clkdiv_out_gate (
    input  logic clk_raw,
    input  logic oem,
    input  logic pdb_n,
    input  logic drive_low,
    output logic out_dat,
    output logic out_oe
);
    logic live;

    // Drive the waveform when live, otherwise release or hold low.
    always_comb begin
        live    = oem && pdb_n;
        out_dat = live && clk_raw;
        out_oe  = live || drive_low;
    end
endmodule

// File: rtl/clkdiv_channel.sv
// Channel top: source selection, programmable division and output gating.
// Assumes cfg_src changes only while pdb_n is low and rst_n is synchronous
// to the selected working clock.
module clkdiv_channel #(
    parameter int PW = clkdiv_pkg::P_W,
    parameter int QW = clkdiv_pkg::POST_W
) (
    input  logic          vco_clk,
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic          cfg_src,
    input  logic [PW-1:0] cfg_p,
    input  logic [QW-1:0] cfg_post,
    input  logic          cfg_drive_low,
    input  logic          oem,
    input  logic          pdb_n,
    output logic          out_dat,
    output logic          out_oe
);
    localparam int CW = PW + (2 ** QW) - 1;

    logic          div_clk, clk_raw, div_odd, div_pos, div_neg;
    logic [CW-1:0] div_cnt, div_ratio;

    clkdiv_src_mux u_mux (
        .clk_a (vco_clk),
        .clk_b (ref_clk),
        .sel   (cfg_src),
        .clk_o (div_clk)
    );

    clkdiv_core #(.PW(PW), .QW(QW), .CW(CW)) u_core (
        .div_clk   (div_clk),
        .rst_n     (rst_n),
        .hold_n    (pdb_n),
        .p_val     (cfg_p),
        .post_code (cfg_post),
        .clk_raw   (clk_raw),
        .cnt_o     (div_cnt),
        .ratio_o   (div_ratio),
        .odd_o     (div_odd),
        .pos_o     (div_pos),
        .neg_o     (div_neg)
    );

    clkdiv_out_gate u_gate (
        .clk_raw   (clk_raw),
        .oem       (oem),
        .pdb_n     (pdb_n),
        .drive_low (cfg_drive_low),
        .out_dat   (out_dat),
        .out_oe    (out_oe)
    );
endmodule

// File: rtl/clkdiv_channel_chk.sv
// Checker: temporal properties of the channel, bound into every instance.
// Assumes the bound signals come from the core and gate of clkdiv_channel.
module clkdiv_channel_chk #(
    parameter int CW = clkdiv_pkg::CNT_W
) (
    input logic          div_clk,
    input logic          rst_n,
    input logic          pdb_n,
    input logic          oem,
    input logic          cfg_drive_low,
    input logic          out_dat,
    input logic          out_oe,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] ratio,
    input logic          odd,
    input logic          pos,
    input logic          neg
);
    // R1: a running counter stays below the captured ratio.
    p_cnt_range_r1: assert property (@(posedge div_clk) disable iff (!rst_n)
        (cnt != '1) |-> (cnt < ratio));

    // R3: the falling-edge stretch is only used for odd ratios.
    p_neg_odd_only_r3: assert property (@(posedge div_clk) disable iff (!rst_n)
        neg |-> odd);

    // R6: the captured ratio only moves after a terminal count.
    p_load_at_tc_r6: assert property (@(posedge div_clk) disable iff (!rst_n)
        (ratio != $past(ratio)) |-> ($past(cnt) >= $past(ratio) - CW'(1)));

    // R7: a live lane is always driven.
    p_live_driven_r7: assert property (@(posedge div_clk) disable iff (!rst_n)
        (oem && pdb_n) |-> out_oe);

    // R7: a gated lane never shows a high level.
    p_gated_low_r7: assert property (@(posedge div_clk) disable iff (!rst_n)
        !(oem && pdb_n) |-> !out_dat);

    // R8: the drive-enable of a gated lane follows the chosen gated state.
    p_gated_mode_r8: assert property (@(posedge div_clk) disable iff (!rst_n)
        !(oem && pdb_n) |-> (out_oe == cfg_drive_low));

    // R9: power-down parks the counter and clears the high phase.
    p_held_r9: assert property (@(posedge div_clk) disable iff (!rst_n)
        !pdb_n |=> ((cnt == '1) && !pos));
endmodule

bind clkdiv_channel clkdiv_channel_chk #(.CW(CW)) u_chk (
    .div_clk       (div_clk),
    .rst_n         (rst_n),
    .pdb_n         (pdb_n),
    .oem           (oem),
    .cfg_drive_low (cfg_drive_low),
    .out_dat       (out_dat),
    .out_oe        (out_oe),
    .cnt           (div_cnt),
    .ratio         (div_ratio),
    .odd           (div_odd),
    .pos           (div_pos),
    .neg           (div_neg)
);

// File: tb/clkdiv_channel_tb_top.sv
// Scoreboard bench: the driver queues expected period and high time,
// and the monitor measures out_dat on a 1 ns grid and compares.
module clkdiv_channel_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic       vco_clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
    logic       oem = 1'b1, pdb_n = 1'b1, cfg_src = 1'b0, cfg_drive_low = 1'b0;
    logic [4:0] cfg_p = 5'd4;
    logic [1:0] cfg_post = 2'd0;
    logic       out_dat, out_oe;

    always #4  vco_clk = ~vco_clk;   // 125 MHz fast source
    always #12 ref_clk = ~ref_clk;   // slower reference

    clkdiv_channel dut_i (
        .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .cfg_src(cfg_src),
        .cfg_p(cfg_p), .cfg_post(cfg_post), .cfg_drive_low(cfg_drive_low),
        .oem(oem), .pdb_n(pdb_n), .out_dat(out_dat), .out_oe(out_oe)
    );

    typedef struct { int period; int high; string req; } exp_t;
    exp_t sb_q[$];
    int   n_cmp = 0, n_bad = 0;

    function automatic void check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    // Measure one full output cycle, rising edge to rising edge, in ns.
    task automatic measure(output int h, output int l);
        int g = 0;
        h = 0; l = 0;
        while (out_dat !== 1'b0 && g < 5000) begin #1; g++; end
        while (out_dat !== 1'b1 && g < 5000) begin #1; g++; end
        while (out_dat === 1'b1 && g < 5000) begin h++; #1; g++; end
        while (out_dat !== 1'b1 && g < 5000) begin l++; #1; g++; end
    endtask

    // Monitor: pops an expectation, skips one settling cycle, compares the next.
    initial begin
        exp_t e;
        int h, l;
        #0.5;
        forever begin
            if (sb_q.size() == 0) #1;
            else begin
                e = sb_q[0];
                measure(h, l);
                measure(h, l);
                check(h + l == e.period, {e.req, " period"}, h + l, e.period);
                check(h == e.high, {e.req, " high time"}, h, e.high);
                void'(sb_q.pop_front());
            end
        end
    end

    task automatic expect_cycle(int per, int hi, string req);
        sb_q.push_back('{per, hi, req});
        while (sb_q.size() != 0) #1;
    endtask

    // Apply a ratio and queue the period and high time the requirements give.
    task automatic run_cfg(int p, int post, string req);
        int t, r;
        cfg_p = 5'(p); cfg_post = 2'(post);
        t = cfg_src ? 24 : 8;
        r = ((p <= 1) ? 1 : p) << post;
        expect_cycle(r * t, r * t / 2, req);
    endtask

    task automatic switch_src(bit s);
        pdb_n = 1'b0; #50;
        cfg_src = s; #50;
        @(negedge vco_clk); pdb_n = 1'b1;
    endtask

    // Count, over 40 ns, the samples that break the given gated state.
    task automatic gated_window(bit want_oe, string req);
        int bad = 0;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (out_oe !== want_oe || out_dat !== 1'b0) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        int h;
        repeat (5) @(posedge vco_clk);
        #1;
        check(out_dat === 1'b0, "R10 out_dat in reset", int'(out_dat), 0);
        check(out_oe === 1'b1, "R10 out_oe in reset", int'(out_oe), 1);
        @(negedge vco_clk); rst_n = 1'b1;

        run_cfg(4, 0, "R2 even P=4");
        run_cfg(5, 0, "R3 odd P=5");
        run_cfg(3, 0, "R3 odd P=3");
        run_cfg(31, 0, "R3 odd P=31");
        run_cfg(3, 2, "R1 P=3 x4");
        run_cfg(7, 3, "R1 P=7 x8");
        run_cfg(6, 1, "R1 P=6 x2");
        run_cfg(1, 0, "R4 P=1 bypass");
        run_cfg(0, 0, "R4 P=0 bypass");
        run_cfg(0, 1, "R1 P=0 x2");

        switch_src(1'b1);
        run_cfg(3, 0, "R5 reference P=3");
        run_cfg(2, 1, "R5 reference P=2 x2");
        switch_src(1'b0);
        run_cfg(2, 0, "R5 fast source P=2");

        // R6: change the ratio just after a rising edge; old pulse completes.
        run_cfg(8, 0, "R6 P=8 setup");
        @(posedge out_dat); #0.5;
        cfg_p = 5'd3;
        h = 0;
        while (out_dat === 1'b1 && h < 1000) begin #1; h++; end
        check(h == 32, "R6 pulse width at change", h, 32);
        expect_cycle(24, 12, "R6 new ratio after change");

        // R7 and R8: master enable gating in both gated states.
        cfg_p = 5'd4;
        expect_cycle(32, 16, "R7 live P=4");
        oem = 1'b0; cfg_drive_low = 1'b0;
        gated_window(1'b0, "R8 oem off high impedance");
        cfg_drive_low = 1'b1;
        gated_window(1'b1, "R8 oem off driven low");
        oem = 1'b1;
        expect_cycle(32, 16, "R7 re-enabled");

        // R9: power-down gating and restart phase.
        cfg_drive_low = 1'b0; pdb_n = 1'b0;
        gated_window(1'b0, "R9 power-down high impedance");
        cfg_drive_low = 1'b1;
        gated_window(1'b1, "R9 power-down driven low");
        @(negedge vco_clk); pdb_n = 1'b1;
        #3.5;
        check(out_dat === 1'b0, "R9 low before first edge", int'(out_dat), 0);
        check(out_oe === 1'b1, "R9 driven after release", int'(out_oe), 1);
        #1;
        check(out_dat === 1'b1, "R9 rise at first edge", int'(out_dat), 1);
        expect_cycle(32, 16, "R9 period after release");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule